// File: doc/BRIEF.md
# PHY Management Bus Master

This block runs register read and write cycles to a physical-layer device over an 8-bit shared address/data bus. A cycle starts when the host side presents a request while the block is idle. The block selects one of two chip selects, drives the register address on the shared lines, and latches it with a pulse on the address-latch output. It then either drives the write data and pulses the write strobe, or releases the lines and pulses the read strobe. The chip select is held low well past the strobe. In a read, the bus value is captured on the clock edge at which the chip select returns high. Every interval is a parameter counted in system-clock cycles.

A sequencer with seven states controls each cycle. ST_IDLE waits for a request. The transition IDLE→LATCH is taken when `req_valid` is high. After that the sequence is fixed: LATCH (latch pulse high, lasting ALE_CYC cycles), then AHOLD (address still driven after the latch falls, AHOLD_CYC), then LEAD (gap before the strobe, LEAD_CYC), then STROBE (read or write strobe low, STB_CYC), then TAIL (strobe high, chip select still low, TAIL_CYC), then RELEASE (chip select high, write data still held, DHOLD_CYC), then back to IDLE. Each of these transitions fires when the state's down-counter reaches zero. The return to IDLE raises a one-cycle done pulse. The block also has two side functions: a PHY reset output held in a host-written control bit, and a PHY interrupt input passed through a two-stage synchroniser.

Top module: `phy_mgmt_bus`

## Requirements
- R1: While `rst_n` is low: `cs_n` = 2'b11, `ale` = 0, `rd_n` = `wr_n` = 1, `ad_oe` = 0, `req_ready` = 1, `done` = 0, `rdata` = 0, `phy_rst` = 1, `phy_int_o` = 0.
- R2: A request is accepted on a clock edge only when `req_ready` and `req_valid` are both high. `req_ready` is low from the next cycle until the cycle in which `done` is high.
- R3: The latch pulse `ale` is high for ALE_CYC cycles. It starts in the cycle after acceptance. During this pulse `ad_oe` = 1 and `ad_o` carries `req_addr`.
- R4: After `ale` falls, the address stays driven and unchanged for AHOLD_CYC more cycles.
- R5: The strobe falls LEAD_CYC cycles after the address hold ends and stays low for STB_CYC cycles. The strobe is `wr_n` when `req_write` = 1 and `rd_n` when `req_write` = 0. The other strobe stays high for the whole cycle.
- R6: The chip select is low for exactly ALE_CYC+AHOLD_CYC+LEAD_CYC+STB_CYC+TAIL_CYC cycles, starting with `ale`. `req_cs` = 0 selects `cs_n[0]` and `req_cs` = 1 selects `cs_n[1]`. At most one chip select is ever low.
- R7: In a write, `ad_oe` stays 1 and `ad_o` = `req_wdata` from the end of the address hold until DHOLD_CYC cycles after the chip select rises.
- R8: In a read, `ad_oe` = 0 from the end of the address hold to the end of the cycle. `rdata` takes the value on `ad_i` at the clock edge where the chip select rises.
- R9: `done` is high for exactly one cycle, the cycle after the release interval. `rdata` stays unchanged until the next read captures.
- R10: A request presented while `req_ready` is low is ignored. It does not start, alter or extend the cycle in progress.
- R11: `phy_int_o` equals the value `phy_int_i` had two rising edges earlier.
- R12: `phy_rst` takes `ctl_rst_val` on an edge where `ctl_we` is high, and holds its value on every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_cs | input | 1 | Chip select choice (0 or 1) |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Block idle, request may be accepted |
| done | output | 1 | One-cycle end-of-cycle pulse |
| rdata | output | 8 | Data captured by the last read |
| ctl_we | input | 1 | Write strobe for the PHY reset control bit |
| ctl_rst_val | input | 1 | New value of the PHY reset control bit |
| ad_o | output | 8 | Shared bus output value |
| ad_oe | output | 1 | Shared bus output enable |
| ad_i | input | 8 | Shared bus input value |
| ale | output | 1 | Address latch pulse, active high |
| cs_n | output | 2 | Chip selects, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| phy_rst | output | 1 | PHY reset, active high |
| phy_int_i | input | 1 | Asynchronous PHY interrupt |
| phy_int_o | output | 1 | Synchronised PHY interrupt |

## Verification
Every port is registered straight from the next-state decode, so a wrong state or a miscounted interval shows on the pins in the same cycle the fault occurs. A stuck counter stretches `ale`, a strobe or the chip select. A misrouted selection drives the wrong `cs_n` bit or turns the bus around at the wrong time. A reference model in the bench follows each cycle by position and compares all outputs on every clock, so any such fault is reported within one cycle. A wrong capture edge for read data appears in `rdata` alongside the `done` pulse, because the bench drives a new bus value every cycle.

// File: rtl/umb_pkg.sv
package umb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LATCH   = 3'd1,
        ST_AHOLD   = 3'd2,
        ST_LEAD    = 3'd3,
        ST_STROBE  = 3'd4,
        ST_TAIL    = 3'd5,
        ST_RELEASE = 3'd6
    } umb_state_e;

    function automatic int unsigned umb_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/umb_sync.sv
module umb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/umb_rst_ctl.sv
module umb_rst_ctl #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic we_i,
    input  logic val_i,
    output logic rst_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_o <= RST_VAL;
        end else if (we_i) begin
            rst_o <= val_i;
        end
    end

    // R12: the control bit moves only on a write edge
    p_rst_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(we_i) |-> $stable(rst_o));
endmodule

// File: rtl/umb_fsm.sv
module umb_fsm
    import umb_pkg::*;
#(
    parameter int BUS_W     = 8,
    parameter int NUM_CS    = 2,
    parameter int ALE_CYC   = 2,
    parameter int AHOLD_CYC = 1,
    parameter int LEAD_CYC  = 2,
    parameter int STB_CYC   = 15,
    parameter int TAIL_CYC  = 2,
    parameter int DHOLD_CYC = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [$clog2(NUM_CS)-1:0]  req_cs,
    input  logic [BUS_W-1:0]           req_addr,
    input  logic [BUS_W-1:0]           req_wdata,
    output logic                       req_ready,
    output logic                       done,
    output logic [BUS_W-1:0]           rdata,
    output logic [BUS_W-1:0]           ad_o,
    output logic                       ad_oe,
    input  logic [BUS_W-1:0]           ad_i,
    output logic                       ale,
    output logic [NUM_CS-1:0]          cs_n,
    output logic                       rd_n,
    output logic                       wr_n
);
    localparam int SEL_W = $clog2(NUM_CS);
    localparam int MAX_D = umb_max(umb_max(umb_max(ALE_CYC, AHOLD_CYC), umb_max(LEAD_CYC, STB_CYC)),
                                   umb_max(TAIL_CYC, DHOLD_CYC));
    localparam int CNT_W = (MAX_D > 1) ? $clog2(MAX_D) : 1;

    umb_state_e        state, nxt;
    logic [CNT_W-1:0]  cnt, cnt_nxt;
    logic              accept;

    logic              cap_wr;
    logic [SEL_W-1:0]  cap_cs;
    logic [BUS_W-1:0]  cap_addr, cap_wdata;
    logic              n_wr;
    logic [SEL_W-1:0]  n_cs;
    logic [BUS_W-1:0]  n_addr, n_wdata;
    logic [NUM_CS-1:0] n_csv;

    function automatic logic [CNT_W-1:0] dur_m1(input umb_state_e s);
        case (s)
            ST_LATCH:   return CNT_W'(ALE_CYC - 1);
            ST_AHOLD:   return CNT_W'(AHOLD_CYC - 1);
            ST_LEAD:    return CNT_W'(LEAD_CYC - 1);
            ST_STROBE:  return CNT_W'(STB_CYC - 1);
            ST_TAIL:    return CNT_W'(TAIL_CYC - 1);
            ST_RELEASE: return CNT_W'(DHOLD_CYC - 1);
            default:    return '0;
        endcase
    endfunction

    // next-state decode
    always_comb begin
        nxt    = state;
        accept = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    nxt    = ST_LATCH;
                    accept = 1'b1;
                end
            end
            ST_LATCH:   if (cnt == '0) nxt = ST_AHOLD;
            ST_AHOLD:   if (cnt == '0) nxt = ST_LEAD;
            ST_LEAD:    if (cnt == '0) nxt = ST_STROBE;
            ST_STROBE:  if (cnt == '0) nxt = ST_TAIL;
            ST_TAIL:    if (cnt == '0) nxt = ST_RELEASE;
            ST_RELEASE: if (cnt == '0) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase

        if (nxt != state) begin
            cnt_nxt = dur_m1(nxt);
        end else if (cnt != '0) begin
            cnt_nxt = cnt - 1'b1;
        end else begin
            cnt_nxt = cnt;
        end

        n_wr    = accept ? req_write : cap_wr;
        n_cs    = accept ? req_cs    : cap_cs;
        n_addr  = accept ? req_addr  : cap_addr;
        n_wdata = accept ? req_wdata : cap_wdata;

        n_csv       = '1;
        n_csv[n_cs] = 1'b0;
    end

    // state register, request capture, read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            cap_wr    <= 1'b0;
            cap_cs    <= '0;
            cap_addr  <= '0;
            cap_wdata <= '0;
            rdata     <= '0;
        end else begin
            state     <= nxt;
            cnt       <= cnt_nxt;
            cap_wr    <= n_wr;
            cap_cs    <= n_cs;
            cap_addr  <= n_addr;
            cap_wdata <= n_wdata;
            if (state == ST_TAIL && nxt == ST_RELEASE && !cap_wr) begin
                rdata <= ad_i;
            end
        end
    end

    // registered pin outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ale       <= 1'b0;
            cs_n      <= '1;
            rd_n      <= 1'b1;
            wr_n      <= 1'b1;
            ad_oe     <= 1'b0;
            ad_o      <= '0;
            req_ready <= 1'b1;
            done      <= 1'b0;
        end else begin
            ale       <= (nxt == ST_LATCH);
            rd_n      <= !(nxt == ST_STROBE && !n_wr);
            wr_n      <= !(nxt == ST_STROBE && n_wr);
            req_ready <= (nxt == ST_IDLE);
            done      <= (state == ST_RELEASE) && (nxt == ST_IDLE);
            unique case (nxt)
                ST_LATCH, ST_AHOLD: begin
                    cs_n  <= n_csv;
                    ad_oe <= 1'b1;
                    ad_o  <= n_addr;
                end
                ST_LEAD, ST_STROBE, ST_TAIL: begin
                    cs_n  <= n_csv;
                    ad_oe <= n_wr;
                    ad_o  <= n_wr ? n_wdata : '0;
                end
                ST_RELEASE: begin
                    cs_n  <= '1;
                    ad_oe <= n_wr;
                    ad_o  <= n_wr ? n_wdata : '0;
                end
                default: begin
                    cs_n  <= '1;
                    ad_oe <= 1'b0;
                    ad_o  <= '0;
                end
            endcase
        end
    end

    // R6: never more than one chip select low
    p_one_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    // R6: a strobe only inside an active chip select
    p_stb_in_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> !(&cs_n));
    // R5: read and write strobes are exclusive
    p_one_stb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));
    // R3: the latch pulse comes with a driven bus and an active select
    p_ale_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (ad_oe && !(&cs_n)));
    // R4: the address outlives the latch pulse unchanged
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> (ad_oe && $stable(ad_o)));
    // R8: the bus is released while the read strobe is low
    p_rd_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);
    // R7: the bus is driven while the write strobe is low
    p_wr_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe);
    // R9: done lasts one cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R2: an accepted request makes the block busy
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
endmodule

// File: rtl/phy_mgmt_bus.sv
module phy_mgmt_bus #(
    parameter int BUS_W     = 8,
    parameter int NUM_CS    = 2,
    parameter int ALE_CYC   = 2,
    parameter int AHOLD_CYC = 1,
    parameter int LEAD_CYC  = 2,
    parameter int STB_CYC   = 15,
    parameter int TAIL_CYC  = 2,
    parameter int DHOLD_CYC = 1,
    parameter int SYNC_STG  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [$clog2(NUM_CS)-1:0] req_cs,
    input  logic [BUS_W-1:0]          req_addr,
    input  logic [BUS_W-1:0]          req_wdata,
    output logic                      req_ready,
    output logic                      done,
    output logic [BUS_W-1:0]          rdata,
    input  logic                      ctl_we,
    input  logic                      ctl_rst_val,
    output logic [BUS_W-1:0]          ad_o,
    output logic                      ad_oe,
    input  logic [BUS_W-1:0]          ad_i,
    output logic                      ale,
    output logic [NUM_CS-1:0]         cs_n,
    output logic                      rd_n,
    output logic                      wr_n,
    output logic                      phy_rst,
    input  logic                      phy_int_i,
    output logic                      phy_int_o
);
    umb_fsm #(
        .BUS_W(BUS_W), .NUM_CS(NUM_CS), .ALE_CYC(ALE_CYC), .AHOLD_CYC(AHOLD_CYC),
        .LEAD_CYC(LEAD_CYC), .STB_CYC(STB_CYC), .TAIL_CYC(TAIL_CYC), .DHOLD_CYC(DHOLD_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_cs(req_cs),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .rdata(rdata),
        .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i),
        .ale(ale), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n)
    );

    umb_rst_ctl #(.RST_VAL(1'b1)) u_rst (
        .clk(clk), .rst_n(rst_n), .we_i(ctl_we), .val_i(ctl_rst_val), .rst_o(phy_rst)
    );

    umb_sync #(.STAGES(SYNC_STG)) u_int_sync (
        .clk(clk), .rst_n(rst_n), .d_i(phy_int_i), .q_o(phy_int_o)
    );
endmodule

// File: tb/phy_mgmt_bus_bench.sv
module phy_mgmt_bus_bench;
    localparam int A = 2, H = 1, L = 2, S = 15, T = 2, D = 1;
    localparam int TOT = A + H + L + S + T;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n, req_valid, req_write, req_cs, ctl_we, ctl_rst_val, phy_int_i;
    logic [7:0] req_addr, req_wdata, ad_i;
    logic       req_ready, done, ad_oe, ale, rd_n, wr_n, phy_rst, phy_int_o;
    logic [7:0] rdata, ad_o;
    logic [1:0] cs_n;

    phy_mgmt_bus #(.ALE_CYC(A), .AHOLD_CYC(H), .LEAD_CYC(L), .STB_CYC(S),
                   .TAIL_CYC(T), .DHOLD_CYC(D)) u_phy_mgmt_bus (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .rdata(rdata),
        .ctl_we(ctl_we), .ctl_rst_val(ctl_rst_val),
        .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i), .ale(ale), .cs_n(cs_n),
        .rd_n(rd_n), .wr_n(wr_n), .phy_rst(phy_rst),
        .phy_int_i(phy_int_i), .phy_int_o(phy_int_o)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit finished = 0, started = 0;

    // behavioural reference model
    bit         m_busy, m_wr, m_done, m_rst, m_int;
    int         m_t, m_cs;
    logic [7:0] m_addr, m_wdata, m_rdata;
    int         iq[$];

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_rdata = 0; m_rst = 1; m_int = 0;
            m_t = 0; m_wr = 0; m_cs = 0; m_addr = 0; m_wdata = 0;
            iq.delete(); iq.push_back(0);
        end else begin
            if (ctl_we) m_rst = ctl_rst_val;
            iq.push_back(int'(phy_int_i));
            m_int = iq.pop_front() != 0;
            m_done = 0;
            if (m_busy) begin
                if (m_t == TOT + D - 1) begin
                    m_busy = 0;
                    m_done = 1;
                end else begin
                    if (m_t == TOT - 1 && !m_wr) m_rdata = ad_i;
                    m_t++;
                end
            end else if (req_valid) begin
                m_busy = 1; m_t = 0; m_wr = req_write; m_cs = int'(req_cs);
                m_addr = req_addr; m_wdata = req_wdata;
            end
        end
    end

    // comparison on every clock, away from the active edge
    always @(negedge clk) begin
        if (started && !finished) begin
            bit   stb, e_oe;
            logic [1:0] e_cs;
            string tg;
            stb  = m_busy && m_t >= A + H + L && m_t < A + H + L + S;
            e_cs = (m_busy && m_t < TOT) ? (2'b11 & ~(2'b01 << m_cs)) : 2'b11;
            e_oe = m_busy && (m_t < A + H || m_wr);
            if (!rst_n) begin
                chk("R1", "cs_n", cs_n, 2'b11);   chk("R1", "ale", ale, 0);
                chk("R1", "rd_n", rd_n, 1);       chk("R1", "wr_n", wr_n, 1);
                chk("R1", "ad_oe", ad_oe, 0);     chk("R1", "req_ready", req_ready, 1);
                chk("R1", "done", done, 0);       chk("R1", "rdata", rdata, 0);
                chk("R1", "phy_rst", phy_rst, 1); chk("R1", "phy_int_o", phy_int_o, 0);
            end else begin
                chk("R3", "ale", ale, m_busy && m_t < A);
                chk("R6", "cs_n", cs_n, e_cs);
                chk("R5", "rd_n", rd_n, !(stb && !m_wr));
                chk("R5", "wr_n", wr_n, !(stb && m_wr));
                tg = !m_busy ? "R1" : (m_t < A + H) ? "R3" : m_wr ? "R7" : "R8";
                chk(tg, "ad_oe", ad_oe, e_oe);
                if (e_oe) begin
                    if (m_t < A) chk("R3", "ad_o addr", ad_o, m_addr);
                    else if (m_t < A + H) chk("R4", "ad_o addr hold", ad_o, m_addr);
                    else chk("R7", "ad_o wdata", ad_o, m_wdata);
                end
                chk((m_busy && req_valid) ? "R10" : "R2", "req_ready", req_ready, !m_busy);
                chk("R9", "done", done, m_done);
                chk("R8", "rdata", rdata, m_rdata);
                chk("R11", "phy_int_o", phy_int_o, m_int);
                chk("R12", "phy_rst", phy_rst, m_rst);
            end
        end
    end

    // bus input changes every cycle so the capture edge matters
    always @(negedge clk) ad_i <= 8'(cyc * 37 + 5);
    always @(negedge clk) if (rst_n && (cyc % 7 == 0)) phy_int_i <= ~phy_int_i;

    task automatic issue(input bit wr, input bit cs, input logic [7:0] a, input logic [7:0] d);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = wr; req_cs = cs; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        rst_n = 0; req_valid = 0; req_write = 0; req_cs = 0; req_addr = 0; req_wdata = 0;
        ctl_we = 0; ctl_rst_val = 0; phy_int_i = 0; ad_i = 0;
        @(negedge clk); started = 1;
        idle(3);
        rst_n = 1;
        idle(2);
        issue(1, 0, 8'h12, 8'hA5);          // R7 write on select 0
        idle(TOT + 4);
        issue(0, 1, 8'h34, 8'h00);          // R8 read on select 1
        idle(TOT + 4);
        issue(1, 1, 8'hF0, 8'h3C);          // R6 select 1 write
        idle(6);
        req_valid = 1; req_write = 0; req_cs = 0; req_addr = 8'h99; // R10 while busy
        idle(3);
        req_valid = 0;
        idle(TOT);
        ctl_we = 1; ctl_rst_val = 0;        // R12 release PHY reset
        @(negedge clk); ctl_we = 0; ctl_rst_val = 1;
        idle(3);
        issue(0, 0, 8'h00, 8'h00);          // R8 read on select 0
        idle(TOT + 4);
        req_valid = 1; req_write = 0; req_cs = 1; req_addr = 8'h55; // R2 back to back
        idle(3 * (TOT + D + 1));
        req_valid = 0;
        idle(TOT + 4);
        ctl_we = 1; ctl_rst_val = 1;        // R12 assert again
        @(negedge clk); ctl_we = 0;
        issue(1, 0, 8'hFF, 8'hFF);
        idle(TOT + 6);
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end
endmodule